// File: doc/BRIEF.md
# Transmit Adapter for a Ready-Latency Stream Sink

This block sits between a packet source that uses an ordinary valid/ready handshake, where a beat moves in any cycle in which both are high, and a packet sink that grants transfer slots ahead of time. The sink raises its ready line to promise a slot a fixed number of cycles later. By default that delay is two cycles; a parameter lowers it to one. The adapter records the recent history of the sink's ready line. It takes a beat from the source only when the following cycle is a granted slot, and it presents that beat to the sink in exactly that slot.

Data, start-of-packet and end-of-packet pass through untouched and in order. After a synchronous reset the adapter waits a minimum number of cycles before it offers any beat, even if the sink held ready high the whole time. Ready values seen during reset never count as grants. Only one output register holds a beat, because the source is told "ready" only when that register's next cycle is a granted slot.

Top module: `rl_tx_adapter`

## Requirements
- R1: While `rst` is high, `src_ready` is low. In the cycle after any clock edge that samples `rst` high, `snk_valid` is low.
- R2: With the default `READY_LAT` of 2, `snk_valid` is high only in a cycle where `snk_ready` was high two cycles earlier. A low `snk_ready` therefore throttles the stream.
- R3: With `READY_LAT` set to 1, `snk_valid` is high only in a cycle where `snk_ready` was high in the previous cycle.
- R4: `snk_ready` values present while `rst` is high are ignored. They never make a cycle after reset release a granted slot.
- R5: Number the first cycle with `rst` low after a reset as cycle 0. `snk_valid` stays low in cycles 0 to `HOLD_CYC`-1 (default 2). When the sink keeps ready high and the source keeps valid high, the first beat appears in cycle `HOLD_CYC`.
- R6: `src_ready` is high in cycle c exactly when all three hold: `rst` is low, c is at least `HOLD_CYC`-1, and cycle c+1 is a granted slot. Cycle c+1 is a granted slot when `snk_ready` was high `READY_LAT`-1 cycles before c, which is cycle c itself when the latency is 1.
- R7: A beat accepted in cycle c (`src_valid` and `src_ready` both high) is presented in cycle c+1 with `snk_valid` high and the same data, start-of-packet flag and end-of-packet flag. `snk_valid` is high in no other cycle.
- R8: Beats leave in the order they were accepted, with none lost or repeated.
- R9: Packet framing is kept. A start-of-packet beat appears only when no packet is open. Every other beat belongs to an open packet. A one-beat packet carries start-of-packet and end-of-packet on the same beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_valid | input | 1 | Source offers a beat |
| src_ready | output | 1 | Adapter takes the offered beat this cycle |
| src_data | input | DATA_W | Source beat payload |
| src_sop | input | 1 | Source beat opens a packet |
| src_eop | input | 1 | Source beat closes a packet |
| snk_valid | output | 1 | Beat presented in a granted slot |
| snk_ready | input | 1 | Sink grant for the slot READY_LAT cycles later |
| snk_data | output | DATA_W | Presented beat payload |
| snk_sop | output | 1 | Presented beat opens a packet |
| snk_eop | output | 1 | Presented beat closes a packet |

## Verification
The hardest situation to reach is the boundary around reset release. The sink holds ready high through reset and the source keeps a beat waiting, so a design that honours ready values seen during reset, or that miscounts the hold-off window, sends its first beat one cycle too early. The stimulus covers this in two places: it opens with this pattern, and it applies a second reset in the middle of traffic. Each time it checks that the first beat appears exactly in cycle 2. Between these points, ready is driven both randomly and in a strict alternating pattern, so that grants arrive in every possible phase against the source's offers. Both the two-cycle and the one-cycle latency variants run side by side under the same ready stream.

// File: rtl/rl_tx_pkg.sv
package rl_tx_pkg;

    // Framing flags that travel with each beat.
    typedef struct packed {
        logic sop;
        logic eop;
    } rl_frame_t;

    // Width of a saturating counter that must reach the given limit.
    function automatic int rl_cnt_width(input int limit);
        return (limit < 1) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/rl_ready_history.sv
module rl_ready_history #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic snk_ready,
    output logic slot_next,
    output logic slot_now
);

    typedef struct packed {
        logic [LAT-1:0] hist;
    } hist_state_t;

    hist_state_t st_d, st_q;

    generate
        if (LAT == 1) begin : g_lat_one
            always_comb begin
                st_d = st_q;
                if (rst) begin
                    st_d.hist = '0;
                end else begin
                    st_d.hist = snk_ready;
                end
            end
            // The grant for the next cycle is the ready value seen now.
            assign slot_next = snk_ready & ~rst;
        end else begin : g_lat_many
            always_comb begin
                st_d = st_q;
                if (rst) begin
                    st_d.hist = '0;
                end else begin
                    st_d.hist = {st_q.hist[LAT-2:0], snk_ready};
                end
            end
            assign slot_next = st_q.hist[LAT-2];
        end
    endgenerate

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign slot_now = st_q.hist[LAT-1];

endmodule

// File: rtl/rl_holdoff.sv
module rl_holdoff #(
    parameter int HOLD = 2
) (
    input  logic clk,
    input  logic rst,
    output logic open_next
);

    localparam int CW = rl_tx_pkg::rl_cnt_width(HOLD);
    localparam logic [CW-1:0] CMAX = CW'(HOLD);
    localparam logic [CW-1:0] LIM  = (HOLD < 1) ? '0 : CW'(HOLD - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } hold_state_t;

    hold_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != CMAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // Cycle index since release equals cnt; the next cycle may carry a beat
    // once its index reaches HOLD.
    assign open_next = ~rst & (st_q.cnt >= LIM);

endmodule

// File: rtl/rl_beat_reg.sv
module rl_beat_reg #(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] in_data,
    input  logic          in_sop,
    input  logic          in_eop,
    output logic          held_valid,
    output logic [DW-1:0] held_data,
    output logic          held_sop,
    output logic          held_eop
);

    import rl_tx_pkg::*;

    typedef struct packed {
        logic          vld;
        rl_frame_t     frm;
        logic [DW-1:0] data;
    } beat_state_t;

    beat_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (rst) begin
            st_d.frm = '0;
        end else if (load) begin
            st_d.vld     = 1'b1;
            st_d.data    = in_data;
            st_d.frm.sop = in_sop;
            st_d.frm.eop = in_eop;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign held_valid = st_q.vld;
    assign held_data  = st_q.data;
    assign held_sop   = st_q.frm.sop;
    assign held_eop   = st_q.frm.eop;

endmodule

// File: rtl/rl_tx_adapter.sv
module rl_tx_adapter #(
    parameter int DATA_W    = 64,
    parameter int READY_LAT = 2,
    parameter int HOLD_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              src_valid,
    output logic              src_ready,
    input  logic [DATA_W-1:0] src_data,
    input  logic              src_sop,
    input  logic              src_eop,
    output logic              snk_valid,
    input  logic              snk_ready,
    output logic [DATA_W-1:0] snk_data,
    output logic              snk_sop,
    output logic              snk_eop
);

    logic slot_next;
    logic slot_now;
    logic open_next;
    logic take;
    logic held_valid;

    rl_ready_history #(.LAT(READY_LAT)) hist_i (
        .clk       (clk),
        .rst       (rst),
        .snk_ready (snk_ready),
        .slot_next (slot_next),
        .slot_now  (slot_now)
    );

    rl_holdoff #(.HOLD(HOLD_CYC)) hold_i (
        .clk       (clk),
        .rst       (rst),
        .open_next (open_next)
    );

    // Take a beat only if the register's next cycle is a granted slot.
    assign src_ready = slot_next & open_next;
    assign take      = src_valid & src_ready;

    rl_beat_reg #(.DW(DATA_W)) beat_i (
        .clk        (clk),
        .rst        (rst),
        .load       (take),
        .in_data    (src_data),
        .in_sop     (src_sop),
        .in_eop     (src_eop),
        .held_valid (held_valid),
        .held_data  (snk_data),
        .held_sop   (snk_sop),
        .held_eop   (snk_eop)
    );

    // The held beat is always due in a granted slot; the slot term keeps
    // valid confined to grants even so.
    assign snk_valid = held_valid & slot_now;

endmodule

// File: rtl/rl_tx_adapter_chk.sv
module rl_tx_adapter_chk #(
    parameter int DATA_W    = 64,
    parameter int READY_LAT = 2,
    parameter int HOLD_CYC  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              src_valid,
    input logic              src_ready,
    input logic [DATA_W-1:0] src_data,
    input logic              src_sop,
    input logic              src_eop,
    input logic              snk_valid,
    input logic              snk_ready,
    input logic [DATA_W-1:0] snk_data,
    input logic              snk_sop,
    input logic              snk_eop
);

    localparam int SW = rl_tx_pkg::rl_cnt_width(HOLD_CYC) + 1;

    // Ready values of past cycles; bit i is i+1 cycles back, reset-era as 0.
    logic [READY_LAT-1:0] seen_q;
    logic [READY_LAT:0]   win;
    logic [SW-1:0]        since_q;
    logic                 open_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q  <= '0;
            since_q <= '0;
            open_q  <= 1'b0;
        end else begin
            seen_q <= {win[READY_LAT-1:0]};
            if (since_q < SW'(HOLD_CYC)) begin
                since_q <= since_q + 1'b1;
            end
            if (snk_valid) begin
                open_q <= ~snk_eop;
            end
        end
    end

    assign win = {seen_q, snk_ready};

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !snk_valid);

    assert_reset_no_take_R1: assert property (@(posedge clk)
        rst |-> !src_ready);

    // R2 for the default latency, R3 when the parameter is 1.
    assert_valid_in_slot_R2: assert property (@(posedge clk) disable iff (rst)
        snk_valid |-> win[READY_LAT]);

    assert_holdoff_R5: assert property (@(posedge clk) disable iff (rst)
        snk_valid |-> (since_q >= SW'(HOLD_CYC)));

    // Also covers R4: grants from reset-era ready are absent from win.
    assert_take_needs_grant_R6: assert property (@(posedge clk) disable iff (rst)
        src_ready |-> win[READY_LAT-1]);

    assert_beat_forward_R7: assert property (@(posedge clk) disable iff (rst)
        (src_valid && src_ready) |=> (snk_valid && snk_data == $past(src_data)
            && snk_sop == $past(src_sop) && snk_eop == $past(src_eop)));

    assert_no_spurious_R7: assert property (@(posedge clk) disable iff (rst)
        snk_valid |-> $past(src_valid && src_ready));

    assert_framing_R9: assert property (@(posedge clk) disable iff (rst)
        snk_valid |-> (snk_sop == !open_q));

endmodule

bind rl_tx_adapter rl_tx_adapter_chk #(
    .DATA_W    (DATA_W),
    .READY_LAT (READY_LAT),
    .HOLD_CYC  (HOLD_CYC)
) chk_i (.*);

// File: tb/rl_tx_adapter_tb_top.sv
module rl_tx_adapter_tb_top;

    localparam int DW   = 32;
    localparam int HOLD = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic snk_ready = 1'b0;

    logic          src_valid_w [2];
    logic          src_ready_w [2];
    logic [DW-1:0] src_data_w  [2];
    logic          src_sop_w   [2];
    logic          src_eop_w   [2];
    logic          snk_valid_w [2];
    logic [DW-1:0] snk_data_w  [2];
    logic          snk_sop_w   [2];
    logic          snk_eop_w   [2];

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    rl_tx_adapter #(.DATA_W(DW), .READY_LAT(2), .HOLD_CYC(HOLD)) dut_i (
        .clk(clk), .rst(rst),
        .src_valid(src_valid_w[0]), .src_ready(src_ready_w[0]),
        .src_data(src_data_w[0]), .src_sop(src_sop_w[0]), .src_eop(src_eop_w[0]),
        .snk_valid(snk_valid_w[0]), .snk_ready(snk_ready),
        .snk_data(snk_data_w[0]), .snk_sop(snk_sop_w[0]), .snk_eop(snk_eop_w[0])
    );

    rl_tx_adapter #(.DATA_W(DW), .READY_LAT(1), .HOLD_CYC(HOLD)) dut_l1_i (
        .clk(clk), .rst(rst),
        .src_valid(src_valid_w[1]), .src_ready(src_ready_w[1]),
        .src_data(src_data_w[1]), .src_sop(src_sop_w[1]), .src_eop(src_eop_w[1]),
        .snk_valid(snk_valid_w[1]), .snk_ready(snk_ready),
        .snk_data(snk_data_w[1]), .snk_sop(snk_sop_w[1]), .snk_eop(snk_eop_w[1])
    );

    // Bench model state
    int            cyc = 0;
    logic [2:0]    rh  = '0;
    bit            sv    [2] = '{0, 0};
    logic [DW-1:0] sd    [2];
    bit            ss    [2] = '{0, 0};
    bit            se    [2] = '{0, 0};
    int            left  [2] = '{0, 0};
    logic [DW-1:0] seqv  [2] = '{32'h100, 32'h8000};
    bit            accp  [2] = '{0, 0};
    bit            open  [2] = '{0, 0};
    int            first_ov [2] = '{-1, -1};
    int            singles = 0;
    logic [DW+1:0] q0 [$];
    logic [DW+1:0] q1 [$];

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit grant_next(input int k, input logic now_rdy, input logic [2:0] h);
        return (k == 0) ? h[0] : now_rdy;
    endfunction

    function automatic bit grant_now(input int k, input logic [2:0] h);
        return (k == 0) ? h[1] : h[0];
    endfunction

    task automatic step(input bit r, input int rp, input int sp);
        logic [DW+1:0] exp_b;
        @(negedge clk);
        rst = r;
        if (rp > 100) snk_ready = ~rh[0];
        else          snk_ready = ($urandom_range(99) < rp);
        for (int k = 0; k < 2; k++) begin
            if (r) begin
                sv[k] = 1'b0;
                left[k] = 0;
                if (sp >= 100) begin
                    sv[k] = 1'b1; ss[k] = 1'b1; se[k] = 1'b1; sd[k] = seqv[k];
                end
            end else if (!sv[k] && ($urandom_range(99) < sp)) begin
                if (left[k] == 0) begin
                    left[k] = $urandom_range(1, 4);
                    ss[k] = 1'b1;
                end else begin
                    ss[k] = 1'b0;
                end
                sd[k] = seqv[k];
                seqv[k] = seqv[k] + 1;
                left[k] = left[k] - 1;
                se[k] = (left[k] == 0);
                sv[k] = 1'b1;
            end
            src_valid_w[k] = sv[k];
            src_data_w[k]  = sd[k];
            src_sop_w[k]   = ss[k];
            src_eop_w[k]   = se[k];
        end
        #1;
        for (int k = 0; k < 2; k++) begin
            bit exp_ir;
            bit acc;
            exp_ir = !r && (cyc >= HOLD - 1) && grant_next(k, snk_ready, rh);
            if (r) chk(src_ready_w[k] == 1'b0, "R1 src_ready in reset", src_ready_w[k], 0);
            else if (cyc < HOLD) chk(src_ready_w[k] == exp_ir, "R4 src_ready after release", src_ready_w[k], exp_ir);
            else chk(src_ready_w[k] == exp_ir, "R6 src_ready", src_ready_w[k], exp_ir);
            if (!r && cyc < HOLD) chk(snk_valid_w[k] == 1'b0, "R5 hold-off", snk_valid_w[k], 0);
            else chk(snk_valid_w[k] == accp[k], "R7 valid follows accept", snk_valid_w[k], accp[k]);
            if (snk_valid_w[k]) begin
                if (k == 0) chk(grant_now(k, rh), "R2 valid in slot", 0, 1);
                else        chk(grant_now(k, rh), "R3 valid in slot", 0, 1);
                if (k == 0) exp_b = (q0.size() > 0) ? q0.pop_front() : '1;
                else        exp_b = (q1.size() > 0) ? q1.pop_front() : '1;
                chk({snk_sop_w[k], snk_eop_w[k], snk_data_w[k]} == exp_b, "R8 beat order",
                    {snk_sop_w[k], snk_eop_w[k], snk_data_w[k]}, exp_b);
                chk(snk_sop_w[k] == !open[k], "R9 framing", snk_sop_w[k], !open[k]);
                if (snk_sop_w[k] && snk_eop_w[k]) singles++;
                open[k] = !snk_eop_w[k];
                if (first_ov[k] < 0) first_ov[k] = cyc;
            end
            acc = sv[k] && src_ready_w[k];
            if (acc) begin
                if (k == 0) q0.push_back({ss[k], se[k], sd[k]});
                else        q1.push_back({ss[k], se[k], sd[k]});
                sv[k] = 1'b0;
            end
            accp[k] = acc;
        end
        rh = {rh[1:0], (r ? 1'b0 : snk_ready)};
        if (r) begin
            cyc = 0;
            q0.delete();
            q1.delete();
            for (int k = 0; k < 2; k++) begin
                open[k] = 1'b0;
                first_ov[k] = -1;
                accp[k] = 1'b0;
            end
        end else begin
            cyc++;
        end
    endtask

    task automatic reset_burst();
        // Ready held high and a beat waiting through reset (R4, R5).
        repeat (3) step(1'b1, 100, 100);
        repeat (6) step(1'b0, 100, 100);
        chk(first_ov[0] == HOLD, "R4 R5 first beat cycle, latency 2", first_ov[0], HOLD);
        chk(first_ov[1] == HOLD, "R3 R5 first beat cycle, latency 1", first_ov[1], HOLD);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < 2; k++) begin
            src_valid_w[k] = 1'b0; src_data_w[k] = '0;
            src_sop_w[k] = 1'b0;  src_eop_w[k] = 1'b0;
            sd[k] = '0;
        end
        reset_burst();
        repeat (3000) step(1'b0, 60, 70);
        repeat (400)  step(1'b0, 101, 100);
        repeat (400)  step(1'b0, 15, 90);
        reset_burst();
        repeat (2000) step(1'b0, 80, 50);
        repeat (8)    step(1'b0, 100, 0);
        chk(q0.size() == 0, "R8 drained, latency 2", q0.size(), 0);
        chk(q1.size() == 0, "R8 drained, latency 1", q1.size(), 0);
        chk(singles > 0, "R9 one-beat packets seen", singles, 1);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule